// File: doc/BRIEF.md
# Periodic Clock-Pulse Offset Trimmer

This block divides a slow oscillator enable (nominally 32.768 kHz) into a one-second tick and trims crystal frequency error. At a fixed correction boundary it lengthens or shortens one second by a programmed, even number of oscillator pulses. This pulls the long-run rate by up to roughly ±190 ppm. One configuration byte sets three things: the correction interval (every 20 or every 60 seconds), the direction, and a 6-bit magnitude. A busy flag guards updates of that byte. The time-of-day counters that consume the tick are outside this block. It exposes only the tick, a second index and a flag that marks a corrected second.

Each step is two pulses. In the 20-second interval one step is about 3051 ppb, and in the 60-second interval about 1017 ppb. The 60-second interval therefore has finer resolution and the 20-second interval has three times the range. An external select input turns correction off while the other clock-trim scheme is in use.

There are two state machines. The update machine has states UPD_IDLE, UPD_SYNC_A and UPD_SYNC_B:
- An accepted write moves it from UPD_IDLE to UPD_SYNC_A.
- Each oscillator enable advances it: from UPD_SYNC_A to UPD_SYNC_B, then from UPD_SYNC_B back to UPD_IDLE.
- On the UPD_SYNC_B to UPD_IDLE step the staged byte becomes the active one.

The second machine has states SEC_PLAIN and SEC_TRIMMED. At every second wrap it enters SEC_TRIMMED when the second that begins is a correction second. Otherwise it enters SEC_PLAIN.

Top module: `pulse_trim_unit`

## Requirements
- R1: While reset is held and right after it, busy, sec_tick and trim_active are 0 and sec_idx is 0.
- R2: An uncorrected second lasts exactly PRESC_COUNT cycles with osc_en high. Cycles with osc_en low do not advance the count. sec_tick is a one-cycle pulse in the cycle after the last counted enable of each second.
- R3: sec_idx holds the index of the second being counted. It advances by one at each tick, wraps from 59 to 0, and is stable between ticks.
- R4: cfg_wdata bit 6 = 0 selects adding. A magnitude field (bits 5:0) of v > 0 lengthens each correction second by 2·(v−1) pulses.
- R5: cfg_wdata bit 6 = 1 selects subtracting. A field v > 0 shortens each correction second by 2·((~v & 63) + 1) pulses. A field of 0 means no correction in either direction.
- R6: cfg_wdata bit 7 = 1 makes only the second with index 0 a correction second. Bit 7 = 0 makes seconds 0, 20 and 40 correction seconds.
- R7: While alt_sel is 1 when a second begins, that second is not corrected.
- R8: A write is accepted only while busy is 0. busy is 1 from the cycle after an accepted write until two further osc_en pulses have been taken. Writes while busy are ignored.
- R9: The new byte applies to every second that begins after busy falls. trim_active is 1 exactly during corrected seconds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_en | input | 1 | One-cycle enable per oscillator period |
| alt_sel | input | 1 | 1 = correction suppressed (other trim scheme selected) |
| cfg_wr | input | 1 | Write strobe for the configuration byte |
| cfg_wdata | input | 8 | Bit 7 interval select, bit 6 subtract, bits 5:0 magnitude |
| busy | output | 1 | Update in progress; writes are ignored |
| sec_tick | output | 1 | One-cycle pulse at the end of each second |
| sec_idx | output | 6 | Index of the second being counted, 0..59 |
| trim_active | output | 1 | Current second is a corrected second |

## Verification
A wrong staging or active byte shows up as a wrong tick spacing at the first correction second after busy falls. That is at most 20 or 60 seconds later. A second index or interval counter that drifts puts the lengthened or shortened second at the wrong tick. It also desynchronises trim_active from the tick stream within one minute. A broken update machine shows at once in the cycle-exact busy window, or in a second write that is not ignored. Because every tick interval is compared with an arithmetic expectation over a full minute, any of these faults appears within one correction period.

// File: rtl/trim_pkg.sv
package trim_pkg;

    // Configuration byte layout: the order matters because the field
    // positions are decoded by the trimmer.
    typedef struct packed {
        logic       long_period;  // bit 7
        logic       subtract;     // bit 6
        logic [5:0] mag;          // bits 5:0
    } trim_cfg_t;

    typedef enum logic [1:0] {
        UPD_IDLE   = 2'd0,
        UPD_SYNC_A = 2'd1,
        UPD_SYNC_B = 2'd2
    } upd_state_e;

    typedef enum logic {
        SEC_PLAIN   = 1'b0,
        SEC_TRIMMED = 1'b1
    } sec_state_e;

endpackage

// File: rtl/trim_decode.sv
module trim_decode #(
    parameter int MAG_W = 6
) (
    input  logic             subtract,
    input  logic [MAG_W-1:0] mag,
    output logic [MAG_W+1:0] pulses,
    output logic             shorten
);
    logic [MAG_W:0] steps;

    always_comb begin
        if (mag == '0) begin
            steps = '0;
        end else if (subtract) begin
            steps = {1'b0, ~mag} + (MAG_W+1)'(1);
        end else begin
            steps = {1'b0, mag} - (MAG_W+1)'(1);
        end
        pulses  = {steps, 1'b0};
        shorten = subtract && (mag != '0);
    end
endmodule

// File: rtl/trim_update_fsm.sv
module trim_update_fsm
    import trim_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      osc_en,
    input  logic      wr,
    input  trim_cfg_t wdata,
    output logic      busy,
    output trim_cfg_t active_cfg
);
    upd_state_e state_q, state_d;
    trim_cfg_t  staged_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= UPD_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UPD_IDLE:   if (wr)     state_d = UPD_SYNC_A;
            UPD_SYNC_A: if (osc_en) state_d = UPD_SYNC_B;
            UPD_SYNC_B: if (osc_en) state_d = UPD_IDLE;
            default:                state_d = UPD_IDLE;
        endcase
    end

    // data held alongside the states
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged_q   <= '0;
            active_cfg <= '0;
        end else begin
            if (state_q == UPD_IDLE && wr) staged_q <= wdata;
            if (state_q == UPD_SYNC_B && osc_en) active_cfg <= staged_q;
        end
    end

    assign busy = (state_q != UPD_IDLE);

    p_busy_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !busy) |=> busy);
    p_busy_needs_osc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !osc_en) |=> busy);
    p_active_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != UPD_SYNC_B) |=> $stable(active_cfg));
endmodule

// File: rtl/trim_prescaler.sv
module trim_prescaler
    import trim_pkg::*;
#(
    parameter int PRESC_COUNT = 32768,
    parameter int SHORT_SECS  = 20,
    parameter int LONG_SECS   = 60,
    parameter int MAG_W       = 6,
    localparam int MAX_PULSES = 2 * ((1 << MAG_W) - 1),
    localparam int LEN_MAX    = PRESC_COUNT + MAX_PULSES,
    localparam int CNT_W      = $clog2(LEN_MAX + 1),
    localparam int IDX_W      = $clog2(LONG_SECS),
    localparam int SUB_W      = $clog2(SHORT_SECS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_en,
    input  logic             alt_sel,
    input  logic             long_period,
    input  logic [MAG_W+1:0] pulses,
    input  logic             shorten,
    output logic             sec_tick,
    output logic [IDX_W-1:0] sec_idx,
    output logic             trim_active
);
    sec_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, len_q, len_d;
    logic [SUB_W-1:0] sub_q, sub_d;
    logic [IDX_W-1:0] idx_d;
    logic             wrap, boundary, do_trim;

    always_comb begin
        wrap  = osc_en && (cnt_q == len_q - CNT_W'(1));
        idx_d = (sec_idx == IDX_W'(LONG_SECS - 1)) ? '0 : sec_idx + IDX_W'(1);
        sub_d = (sub_q == SUB_W'(SHORT_SECS - 1) || sec_idx == IDX_W'(LONG_SECS - 1))
                ? '0 : sub_q + SUB_W'(1);
        boundary = long_period ? (idx_d == '0) : (sub_d == '0);
        do_trim  = boundary && !alt_sel && (pulses != '0);
        if (!do_trim)     len_d = CNT_W'(PRESC_COUNT);
        else if (shorten) len_d = CNT_W'(PRESC_COUNT) - CNT_W'(pulses);
        else              len_d = CNT_W'(PRESC_COUNT) + CNT_W'(pulses);
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEC_PLAIN:   if (wrap) state_d = do_trim ? SEC_TRIMMED : SEC_PLAIN;
            SEC_TRIMMED: if (wrap) state_d = do_trim ? SEC_TRIMMED : SEC_PLAIN;
            default:               state_d = SEC_PLAIN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEC_PLAIN;
        else        state_q <= state_d;
    end

    // counters and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            len_q    <= CNT_W'(PRESC_COUNT);
            sec_idx  <= '0;
            sub_q    <= '0;
            sec_tick <= 1'b0;
        end else begin
            sec_tick <= wrap;
            if (wrap) begin
                cnt_q   <= '0;
                len_q   <= len_d;
                sec_idx <= idx_d;
                sub_q   <= sub_d;
            end else if (osc_en) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign trim_active = (state_q == SEC_TRIMMED);

    p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick);
    p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sec_idx < IDX_W'(LONG_SECS));
    p_idx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |-> $stable(sec_idx));
    p_len_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(len_q) >= PRESC_COUNT - MAX_PULSES) && (int'(len_q) <= LEN_MAX));
    p_cnt_below_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < len_q);
    p_trim_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |-> $stable(trim_active));
    p_alt_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && alt_sel) |=> !trim_active);
endmodule

// File: rtl/pulse_trim_unit.sv
module pulse_trim_unit
    import trim_pkg::*;
#(
    parameter int PRESC_COUNT = 32768,
    parameter int SHORT_SECS  = 20,
    parameter int LONG_SECS   = 60,
    parameter int MAG_W       = 6,
    localparam int IDX_W      = $clog2(LONG_SECS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_en,
    input  logic             alt_sel,
    input  logic             cfg_wr,
    input  logic [7:0]       cfg_wdata,
    output logic             busy,
    output logic             sec_tick,
    output logic [IDX_W-1:0] sec_idx,
    output logic             trim_active
);
    trim_cfg_t        active_cfg;
    logic [MAG_W+1:0] pulses;
    logic             shorten;

    trim_update_fsm u_update (
        .clk        (clk),
        .rst_n      (rst_n),
        .osc_en     (osc_en),
        .wr         (cfg_wr),
        .wdata      (trim_cfg_t'(cfg_wdata)),
        .busy       (busy),
        .active_cfg (active_cfg)
    );

    trim_decode #(.MAG_W(MAG_W)) u_decode (
        .subtract (active_cfg.subtract),
        .mag      (active_cfg.mag),
        .pulses   (pulses),
        .shorten  (shorten)
    );

    trim_prescaler #(
        .PRESC_COUNT (PRESC_COUNT),
        .SHORT_SECS  (SHORT_SECS),
        .LONG_SECS   (LONG_SECS),
        .MAG_W       (MAG_W)
    ) u_presc (
        .clk         (clk),
        .rst_n       (rst_n),
        .osc_en      (osc_en),
        .alt_sel     (alt_sel),
        .long_period (active_cfg.long_period),
        .pulses      (pulses),
        .shorten     (shorten),
        .sec_tick    (sec_tick),
        .sec_idx     (sec_idx),
        .trim_active (trim_active)
    );

    p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> (!busy && !sec_tick && sec_idx == '0));
endmodule

// File: tb/pulse_trim_unit_bench.sv
module pulse_trim_unit_bench;
    localparam int P = 160;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b0;
    logic       alt_sel = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       busy, sec_tick, trim_active;
    logic [5:0] sec_idx;

    int  checks = 0, errors = 0;
    int  tick_no = 0, acc = 0;
    bit  mon_on = 0, chk_on = 0, osc_run = 0, gap_mode = 0, done = 0;
    int  exp_delta = 0;
    bit  exp_long = 0, exp_alt = 0;

    always #2 clk = ~clk;

    pulse_trim_unit #(.PRESC_COUNT(P)) u_pulse_trim_unit (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .alt_sel(alt_sel),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .busy(busy),
        .sec_tick(sec_tick), .sec_idx(sec_idx), .trim_active(trim_active)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (tick %0d)", tag, act, exp, tick_no);
        end
    endtask

    function automatic bit is_corr(input int s);
        return exp_long ? (s == 0) : (s % 20 == 0);
    endfunction

    // oscillator enable driver
    initial begin
        bit ph;
        ph = 0;
        forever begin
            @(posedge clk); #1;
            ph = ~ph;
            osc_en = osc_run && (!gap_mode || ph);
        end
    end

    // monitor: measures enables per second, checks index and trim flag
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on) begin
                if (sec_tick) begin
                    int s, exp_len;
                    bit corr, nxt;
                    tick_no++;
                    s = (tick_no - 1) % 60;
                    corr = is_corr(s) && !exp_alt && exp_delta != 0;
                    exp_len = P + (corr ? exp_delta : 0);
                    if (chk_on) begin
                        if (exp_alt && is_corr(s))
                            check(acc == exp_len, "R7 alt second length", acc, exp_len);
                        else if (corr && exp_delta > 0)
                            check(acc == exp_len, "R4 lengthened second", acc, exp_len);
                        else if (corr)
                            check(acc == exp_len, "R5 shortened second", acc, exp_len);
                        else if (is_corr(s))
                            check(acc == exp_len, "R6 boundary w/o trim", acc, exp_len);
                        else
                            check(acc == exp_len, "R2 plain second", acc, exp_len);
                        nxt = is_corr(tick_no % 60) && !exp_alt && exp_delta != 0;
                        check(trim_active == nxt, "R9 trim_active", int'(trim_active), int'(nxt));
                        check(int'(sec_idx) == tick_no % 60, "R3 sec_idx", int'(sec_idx), tick_no % 60);
                    end
                    acc = 0;
                end
                if (osc_en) acc++;
            end
        end
    end

    task automatic write_cfg(input logic [7:0] v);
        @(posedge clk); #1;
        cfg_wdata = v; cfg_wr = 1'b1;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic measure(input int delta, input bit lng, input bit alt, input int nsec);
        int t0;
        exp_delta = delta; exp_long = lng; exp_alt = alt;
        t0 = tick_no;
        wait (tick_no >= t0 + 2);
        chk_on = 1;
        wait (tick_no >= t0 + 2 + nsec);
        chk_on = 0;
    endtask

    task automatic run_cfg(input logic [7:0] v, input int delta, input bit alt, input int nsec);
        alt_sel = alt;
        write_cfg(v);
        measure(delta, v[7], alt, nsec);
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(busy == 0, "R1 busy in reset", int'(busy), 0);
        check(sec_tick == 0, "R1 tick in reset", int'(sec_tick), 0);
        check(sec_idx == 0, "R1 idx in reset", int'(sec_idx), 0);
        check(trim_active == 0, "R1 trim in reset", int'(trim_active), 0);
        @(posedge clk); #1;
        rst_n = 1'b1; mon_on = 1;
        @(negedge clk);
        check(busy == 0 && sec_idx == 0, "R1 after reset", int'(busy), 0);
        @(posedge clk); #1;
        osc_run = 1;

        // R8: busy window and ignored second write (A = 60 s, add 62)
        @(posedge clk); #1;
        cfg_wdata = 8'hBF; cfg_wr = 1'b1;
        @(negedge clk);
        check(busy == 0, "R8 busy before sample", int'(busy), 0);
        @(posedge clk); #1;
        cfg_wdata = 8'h42; cfg_wr = 1'b1;
        @(negedge clk);
        check(busy == 1, "R8 busy after write", int'(busy), 1);
        @(posedge clk); #1;
        cfg_wr = 1'b0;
        @(negedge clk);
        check(busy == 1, "R8 busy second cycle", int'(busy), 1);
        @(negedge clk);
        check(busy == 0, "R8 busy cleared after two enables", int'(busy), 0);
        measure(124, 1, 0, 60);   // second write ignored: still add 62

        // near-exhaustive sweep over intervals, directions and edge fields
        run_cfg(8'h3F,  124, 0, 60);  // 20 s, add 62
        run_cfg(8'h42, -124, 0, 60);  // 20 s, subtract 62
        run_cfg(8'hC1, -126, 0, 60);  // 60 s, subtract field 1 -> 63 steps
        run_cfg(8'h82,    2, 0, 60);  // 60 s, add 1
        run_cfg(8'h01,    0, 0, 40);  // add field 1 -> zero steps
        run_cfg(8'h40,    0, 0, 40);  // subtract with field 0 -> none
        run_cfg(8'hE1,  -62, 0, 60);  // 60 s, subtract 31
        run_cfg(8'h15,   40, 1, 60);  // alt_sel suppresses add 20
        alt_sel = 1'b0;
        gap_mode = 1;
        run_cfg(8'h7B,  -10, 0, 41);  // enables with gaps, subtract 5

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule